// File: doc/BRIEF.md
# Tagged Address Translation Cache

This block is a small, fully associative cache of address translations. Each slot holds one translation. The translation is tagged with an 8-bit address space identifier, and it covers either a 4 KB small page or a 1 MB section. A lookup presents a 32-bit virtual address together with the current identifier. Every slot is compared in parallel. The result is registered and reports one of four things:
- nothing matched;
- exactly one slot matched, and the physical address is returned;
- exactly one slot matched, but that slot carries no physical base, which is a fault;
- two or more slots matched, which is reported as an inconsistent state.

A separate port loads new translations. It fills the lowest free slot, or evicts a slot in round-robin order when the cache is full. It never checks for duplicates, so software can create conflicting entries. The inconsistent result exists to expose them.

A third port removes entries. It has three scopes: identifier and address together, identifier only, and address only. One command removes every entry in its scope, duplicates included, in a single cycle.

Top module: `tagged_tlb`

## Requirements
- R1: `res_valid_o` is high in exactly the cycle after a cycle in which `lk_valid_i` was sampled high. When no lookup is taken, `res_kind_o` and `res_pa_o` keep their previous values.
- R2: A valid slot matches a lookup only when its stored identifier equals `lk_asid_i`. A small-page slot must also have `lk_va_i[31:12]` equal to its 20-bit virtual base. A section slot must instead have `lk_va_i[31:20]` equal to bits [19:8] of its virtual base.
- R3: Result codes are 2'b00 miss (no match), 2'b01 hit (one match) and 2'b11 fault (one match with an absent physical base). Two or more matches give 2'b10 inconsistent, whatever the slots contain.
- R4: On a hit, `res_pa_o` is the physical base followed by the untranslated offset. A small page gives {base[19:0], va[11:0]}. A section gives {base[19:8], va[19:0]}. For every other result `res_pa_o` is zero.
- R5: A slot loaded with `fill_absent_i`=1 produces the fault code, with a zero address, when it is the only match.
- R6: Invalidate code 2'b00 removes every slot that matches both `inv_asid_i` and `inv_vpn_i` (address bits [31:12]), duplicates included. A following lookup of that pair misses.
- R7: Invalidate code 2'b01 removes every slot with identifier `inv_asid_i`, whatever its address. Lookups under any other identifier return the same result as before.
- R8: Invalidate code 2'b10 removes every slot whose page covers the address `inv_vpn_i`, whatever its identifier. Invalidate code 2'b11 removes nothing.
- R9: A load writes the lowest-numbered invalid slot. When all slots are valid it replaces the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each replacement. A load never checks for existing duplicates.
- R10: An invalidate with code 2'b00, 2'b01 or 2'b10 in the same cycle as a load wins: the load is dropped. A load alongside code 2'b11 proceeds.
- R11: After reset every slot is invalid, `res_valid_o` is 0, `res_kind_o` is 2'b00 and `res_pa_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_asid_i | input | 8 | Lookup identifier |
| lk_va_i | input | 32 | Lookup virtual address |
| fill_valid_i | input | 1 | Load request |
| fill_asid_i | input | 8 | Identifier of the new entry |
| fill_sect_i | input | 1 | 1 = section, 0 = small page |
| fill_vbase_i | input | 20 | Virtual base (a section uses [19:8]) |
| fill_pbase_i | input | 20 | Physical base (a section uses [19:8]) |
| fill_absent_i | input | 1 | Physical base absent (fault entry) |
| inv_valid_i | input | 1 | Invalidate request |
| inv_kind_i | input | 2 | Invalidate scope code |
| inv_asid_i | input | 8 | Identifier to invalidate |
| inv_vpn_i | input | 20 | Address bits [31:12] to invalidate |
| res_valid_o | output | 1 | Lookup result valid |
| res_kind_o | output | 2 | Lookup result code |
| res_pa_o | output | 32 | Translated physical address |

## Verification
A lookup is evaluated against the slot contents as they stand before the sampling edge, and its result appears after that same edge. The bench therefore drives each request on a falling edge and checks the outputs on the next falling edge. Loads and invalidates change the slots at the edge that samples them. The bench updates its own model of the slots at that point, so a lookup issued in the following cycle already sees the change. The hold behaviour is checked one further idle cycle later.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ASID_W = 8;
  localparam int VA_W   = 32;
  localparam int VPN_W  = 20;
  localparam int SECT_W = 12;

  typedef struct packed {
    logic              vld;
    logic [ASID_W-1:0] asid;
    logic              sect;
    logic [VPN_W-1:0]  vbase;
    logic [VPN_W-1:0]  pbase;
    logic              pabs;
  } tlb_ent_t;

  typedef enum logic [1:0] {
    RES_MISS  = 2'b00,
    RES_HIT   = 2'b01,
    RES_MULTI = 2'b10,
    RES_FAULT = 2'b11
  } res_kind_e;

  typedef enum logic [1:0] {
    INV_PAIR = 2'b00,
    INV_ASID = 2'b01,
    INV_ADDR = 2'b10,
    INV_NONE = 2'b11
  } inv_kind_e;
endpackage

// File: rtl/tlb_cmp.sv
module tlb_cmp
  import tlb_pkg::*;
(
  input  logic              vld_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              sect_i,
  input  logic [VPN_W-1:0]  vbase_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic              inv_en_i,
  input  logic [1:0]        inv_kind_i,
  input  logic [ASID_W-1:0] inv_asid_i,
  input  logic [VPN_W-1:0]  inv_vpn_i,
  output logic              lk_hit_o,
  output logic              kill_o
);
  logic lk_cover, inv_cover;

  // section compares only the upper SECT_W bits
  assign lk_cover  = sect_i ? (lk_vpn_i[VPN_W-1 -: SECT_W] == vbase_i[VPN_W-1 -: SECT_W])
                            : (lk_vpn_i == vbase_i);
  assign inv_cover = sect_i ? (inv_vpn_i[VPN_W-1 -: SECT_W] == vbase_i[VPN_W-1 -: SECT_W])
                            : (inv_vpn_i == vbase_i);

  assign lk_hit_o = vld_i && (asid_i == lk_asid_i) && lk_cover;

  always_comb begin
    kill_o = 1'b0;
    if (inv_en_i && vld_i) begin
      unique case (inv_kind_i)
        INV_PAIR: kill_o = (asid_i == inv_asid_i) && inv_cover;
        INV_ASID: kill_o = (asid_i == inv_asid_i);
        INV_ADDR: kill_o = inv_cover;
        default:  kill_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  vld_i,
  input  logic          take_i,
  output logic [IW-1:0] slot_o
);
  logic [IW-1:0] rr_q, free_idx;
  logic          any_free;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_i[i]) begin
        any_free = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  assign slot_o = any_free ? free_idx : rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rr_q <= '0;
    else if (take_i && !any_free) rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/tlb_outcome.sv
module tlb_outcome
  import tlb_pkg::*;
#(
  parameter int N  = 8,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]     hit_i,
  input  logic             sect_i  [N],
  input  logic [VPN_W-1:0] pbase_i [N],
  input  logic             pabs_i  [N],
  input  logic [VA_W-1:0]  va_i,
  output logic [1:0]       kind_o,
  output logic [VA_W-1:0]  pa_o
);
  logic [CW-1:0]   cnt;
  logic [VA_W-1:0] pa_or;
  logic            abs_or;

  always_comb begin
    cnt    = '0;
    pa_or  = '0;
    abs_or = 1'b0;
    for (int i = 0; i < N; i++) begin
      cnt = cnt + CW'(hit_i[i]);
      if (hit_i[i]) begin
        abs_or = abs_or | pabs_i[i];
        pa_or  = pa_or | (sect_i[i]
                 ? {pbase_i[i][VPN_W-1 -: SECT_W], va_i[VA_W-SECT_W-1:0]}
                 : {pbase_i[i], va_i[VA_W-VPN_W-1:0]});
      end
    end
    kind_o = RES_MISS;
    pa_o   = '0;
    if (cnt > CW'(1))  kind_o = RES_MULTI;
    else if (cnt == CW'(1)) begin
      if (abs_or) kind_o = RES_FAULT;
      else begin
        kind_o = RES_HIT;
        pa_o   = pa_or;
      end
    end
  end
endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb
  import tlb_pkg::*;
#(
  parameter int NUM_ENT = 8,
  localparam int IW = $clog2(NUM_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [VA_W-1:0]   lk_va_i,
  input  logic              fill_valid_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic              fill_sect_i,
  input  logic [VPN_W-1:0]  fill_vbase_i,
  input  logic [VPN_W-1:0]  fill_pbase_i,
  input  logic              fill_absent_i,
  input  logic              inv_valid_i,
  input  logic [1:0]        inv_kind_i,
  input  logic [ASID_W-1:0] inv_asid_i,
  input  logic [VPN_W-1:0]  inv_vpn_i,
  output logic              res_valid_o,
  output logic [1:0]        res_kind_o,
  output logic [VA_W-1:0]   res_pa_o
);
  tlb_ent_t         ent_q [NUM_ENT];
  logic [NUM_ENT-1:0] vld_vec, hit_vec, kill_vec;
  logic             e_sect  [NUM_ENT];
  logic [VPN_W-1:0] e_pbase [NUM_ENT];
  logic             e_pabs  [NUM_ENT];
  logic [IW-1:0]    slot;
  logic             inv_act, fill_go;
  logic [1:0]       kind_d;
  logic [VA_W-1:0]  pa_d;
  logic             res_valid_q;
  logic [1:0]       res_kind_q;
  logic [VA_W-1:0]  res_pa_q;

  // an effective invalidate blocks a same-cycle load
  assign inv_act = inv_valid_i && (inv_kind_i != INV_NONE);
  assign fill_go = fill_valid_i && !inv_act;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    assign vld_vec[g] = ent_q[g].vld;
    assign e_sect[g]  = ent_q[g].sect;
    assign e_pbase[g] = ent_q[g].pbase;
    assign e_pabs[g]  = ent_q[g].pabs;

    tlb_cmp u_cmp (
      .vld_i      (ent_q[g].vld),
      .asid_i     (ent_q[g].asid),
      .sect_i     (ent_q[g].sect),
      .vbase_i    (ent_q[g].vbase),
      .lk_asid_i  (lk_asid_i),
      .lk_vpn_i   (lk_va_i[VA_W-1 -: VPN_W]),
      .inv_en_i   (inv_act),
      .inv_kind_i (inv_kind_i),
      .inv_asid_i (inv_asid_i),
      .inv_vpn_i  (inv_vpn_i),
      .lk_hit_o   (hit_vec[g]),
      .kill_o     (kill_vec[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[g] <= '0;
      end else if (kill_vec[g]) begin
        ent_q[g].vld <= 1'b0;
      end else if (fill_go && (slot == IW'(g))) begin
        ent_q[g] <= '{vld: 1'b1, asid: fill_asid_i, sect: fill_sect_i,
                      vbase: fill_vbase_i, pbase: fill_pbase_i, pabs: fill_absent_i};
      end
    end
  end

  tlb_victim #(.N(NUM_ENT)) u_victim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (vld_vec),
    .take_i (fill_go),
    .slot_o (slot)
  );

  tlb_outcome #(.N(NUM_ENT)) u_outcome (
    .hit_i   (hit_vec),
    .sect_i  (e_sect),
    .pbase_i (e_pbase),
    .pabs_i  (e_pabs),
    .va_i    (lk_va_i),
    .kind_o  (kind_d),
    .pa_o    (pa_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      res_kind_q  <= RES_MISS;
      res_pa_q    <= '0;
    end else begin
      res_valid_q <= lk_valid_i;
      if (lk_valid_i) begin
        res_kind_q <= kind_d;
        res_pa_q   <= pa_d;
      end
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_kind_o  = res_kind_q;
  assign res_pa_o    = res_pa_q;
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk
  import tlb_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lk_valid_i,
  input logic [ASID_W-1:0] lk_asid_i,
  input logic [VA_W-1:0]   lk_va_i,
  input logic              inv_valid_i,
  input logic [1:0]        inv_kind_i,
  input logic [ASID_W-1:0] inv_asid_i,
  input logic [VPN_W-1:0]  inv_vpn_i,
  input logic              res_valid_o,
  input logic [1:0]        res_kind_o,
  input logic [VA_W-1:0]   res_pa_o
);
  // R1
  res_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o == $past(lk_valid_i));

  // R1
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(lk_valid_i) |-> ($stable(res_kind_o) && $stable(res_pa_o)));

  // R4
  small_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_kind_o == RES_HIT) |-> res_pa_o[11:0] == $past(lk_va_i[11:0]));

  // R6
  pair_gone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && $past(inv_valid_i, 2) && $past(inv_kind_i, 2) == INV_PAIR &&
     $past(inv_asid_i, 2) == $past(lk_asid_i) &&
     $past(inv_vpn_i, 2) == $past(lk_va_i[VA_W-1 -: VPN_W])) |-> res_kind_o == RES_MISS);

  // R7
  asid_gone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && $past(inv_valid_i, 2) && $past(inv_kind_i, 2) == INV_ASID &&
     $past(inv_asid_i, 2) == $past(lk_asid_i)) |-> res_kind_o == RES_MISS);

  // R8
  addr_gone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && $past(inv_valid_i, 2) && $past(inv_kind_i, 2) == INV_ADDR &&
     $past(inv_vpn_i, 2) == $past(lk_va_i[VA_W-1 -: VPN_W])) |-> res_kind_o == RES_MISS);
endmodule

bind tagged_tlb tlb_chk u_chk (.*);

// File: tb/sim_tagged_tlb.sv
module sim_tagged_tlb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid_i = 1'b0;
  logic [7:0]  lk_asid_i = '0;
  logic [31:0] lk_va_i = '0;
  logic        fill_valid_i = 1'b0;
  logic [7:0]  fill_asid_i = '0;
  logic        fill_sect_i = 1'b0;
  logic [19:0] fill_vbase_i = '0;
  logic [19:0] fill_pbase_i = '0;
  logic        fill_absent_i = 1'b0;
  logic        inv_valid_i = 1'b0;
  logic [1:0]  inv_kind_i = '0;
  logic [7:0]  inv_asid_i = '0;
  logic [19:0] inv_vpn_i = '0;
  logic        res_valid_o;
  logic [1:0]  res_kind_o;
  logic [31:0] res_pa_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model of the slots
  logic        m_v    [8];
  logic [7:0]  m_asid [8];
  logic        m_sect [8];
  logic [19:0] m_vb   [8];
  logic [19:0] m_pb   [8];
  logic        m_abs  [8];
  int          m_rr;

  always #5 clk_i = ~clk_i;

  tagged_tlb u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit covers(input logic sect, input logic [19:0] vb, input logic [19:0] vpn);
    return sect ? (vpn[19:8] == vb[19:8]) : (vpn == vb);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
    m_rr = 0;
  endtask

  task automatic exp_look(input logic [7:0] a, input logic [31:0] va,
                          output logic [1:0] k, output logic [31:0] pa);
    int n = 0;
    int idx = 0;
    for (int i = 0; i < 8; i++)
      if (m_v[i] && m_asid[i] == a && covers(m_sect[i], m_vb[i], va[31:12])) begin
        n++;
        idx = i;
      end
    pa = '0;
    if (n == 0) k = 2'b00;
    else if (n > 1) k = 2'b10;
    else if (m_abs[idx]) k = 2'b11;
    else begin
      k = 2'b01;
      pa = m_sect[idx] ? {m_pb[idx][19:8], va[19:0]} : {m_pb[idx], va[11:0]};
    end
  endtask

  task automatic look(input logic [7:0] a, input logic [31:0] va, input string req);
    logic [1:0] ek;
    logic [31:0] ep;
    exp_look(a, va, ek, ep);
    lk_valid_i = 1'b1;
    lk_asid_i = a;
    lk_va_i = va;
    @(posedge clk_i);
    @(negedge clk_i);
    lk_valid_i = 1'b0;
    chk(res_valid_o == 1'b1, req, {31'd0, res_valid_o}, 32'd1);
    chk(res_kind_o == ek, req, {30'd0, res_kind_o}, {30'd0, ek});
    chk(res_pa_o == ep, req, res_pa_o, ep);
  endtask

  task automatic cmd(input bit fv, input logic [7:0] fa, input logic fs, input logic [19:0] fvb,
                     input logic [19:0] fpb, input logic fab,
                     input bit iv, input logic [1:0] ik, input logic [7:0] ia, input logic [19:0] ivp);
    bit inv_eff;
    int slot;
    fill_valid_i = fv; fill_asid_i = fa; fill_sect_i = fs;
    fill_vbase_i = fvb; fill_pbase_i = fpb; fill_absent_i = fab;
    inv_valid_i = iv; inv_kind_i = ik; inv_asid_i = ia; inv_vpn_i = ivp;
    @(posedge clk_i);
    inv_eff = iv && (ik != 2'b11);
    if (inv_eff) begin
      for (int i = 0; i < 8; i++) begin
        bit kill;
        kill = 0;
        if (m_v[i]) begin
          if (ik == 2'b00) kill = (m_asid[i] == ia) && covers(m_sect[i], m_vb[i], ivp);
          else if (ik == 2'b01) kill = (m_asid[i] == ia);
          else kill = covers(m_sect[i], m_vb[i], ivp);
        end
        if (kill) m_v[i] = 1'b0;
      end
    end else if (fv) begin
      slot = -1;
      for (int i = 7; i >= 0; i--) if (!m_v[i]) slot = i;
      if (slot < 0) begin
        slot = m_rr;
        m_rr = (m_rr + 1) % 8;
      end
      m_v[slot] = 1'b1; m_asid[slot] = fa; m_sect[slot] = fs;
      m_vb[slot] = fvb; m_pb[slot] = fpb; m_abs[slot] = fab;
    end
    @(negedge clk_i);
    fill_valid_i = 1'b0;
    inv_valid_i = 1'b0;
  endtask

  task automatic fill(input logic [7:0] a, input logic s, input logic [19:0] vb,
                      input logic [19:0] pb, input logic ab);
    cmd(1, a, s, vb, pb, ab, 0, 2'b00, 8'd0, 20'd0);
  endtask

  task automatic inv(input logic [1:0] k, input logic [7:0] a, input logic [19:0] vpn);
    cmd(0, 8'd0, 1'b0, 20'd0, 20'd0, 1'b0, 1, k, a, vpn);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    model_clear();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    logic [1:0] held_kind;
    void'($urandom(32'd1234));
    model_clear();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R11 reset state
    chk(res_valid_o == 1'b0, "R11", {31'd0, res_valid_o}, 32'd0);
    chk(res_kind_o == 2'b00, "R11", {30'd0, res_kind_o}, 32'd0);
    chk(res_pa_o == 32'd0, "R11", res_pa_o, 32'd0);
    look(8'd1, 32'h1234_5678, "R11");

    // R2 R4 small page
    fill(8'd1, 1'b0, 20'h12345, 20'hABCDE, 1'b0);
    look(8'd1, 32'h1234_5678, "R4");
    look(8'd2, 32'h1234_5678, "R2");
    look(8'd1, 32'h1234_6678, "R2");

    // R1 hold over an idle cycle
    held_kind = res_kind_o;
    @(negedge clk_i);
    chk(res_valid_o == 1'b0, "R1", {31'd0, res_valid_o}, 32'd0);
    chk(res_kind_o == held_kind, "R1", {30'd0, res_kind_o}, {30'd0, held_kind});

    // R2 R4 section
    fill(8'd1, 1'b1, 20'h80000, 20'h12300, 1'b0);
    look(8'd1, 32'h800F_FFFF, "R4");
    look(8'd1, 32'h8010_0000, "R2");

    // R5 absent base
    fill(8'd3, 1'b0, 20'h00042, 20'h0, 1'b1);
    look(8'd3, 32'h0004_2010, "R5");

    // R3 duplicate, R6 pair invalidate removes both
    fill(8'd1, 1'b0, 20'h12345, 20'h11111, 1'b0);
    look(8'd1, 32'h1234_5000, "R3");
    inv(2'b00, 8'd1, 20'h12345);
    look(8'd1, 32'h1234_5000, "R6");
    look(8'd1, 32'h8000_0004, "R6");

    // R7 identifier invalidate
    fill(8'd2, 1'b0, 20'h55555, 20'h22222, 1'b0);
    inv(2'b01, 8'd1, 20'h0);
    look(8'd1, 32'h8000_0004, "R7");
    look(8'd2, 32'h5555_5ABC, "R7");

    // R8 address invalidate across identifiers; code 11 is a no-op
    fill(8'd2, 1'b0, 20'h66666, 20'h33333, 1'b0);
    fill(8'd3, 1'b0, 20'h66666, 20'h44444, 1'b0);
    inv(2'b10, 8'd0, 20'h66666);
    look(8'd2, 32'h6666_6000, "R8");
    look(8'd3, 32'h6666_6000, "R8");
    cmd(1, 8'd5, 1'b0, 20'h0ABCD, 20'h0F0F0, 1'b0, 1, 2'b11, 8'd2, 20'h55555);
    look(8'd2, 32'h5555_5000, "R8");
    look(8'd5, 32'h0ABC_D123, "R10");

    // R10 invalidate wins over same-cycle load
    cmd(1, 8'd4, 1'b0, 20'h77777, 20'h12121, 1'b0, 1, 2'b01, 8'd9, 20'h0);
    look(8'd4, 32'h7777_7000, "R10");

    // R9 placement and round robin
    do_reset();
    for (int i = 0; i < 9; i++) fill(8'd6, 1'b0, 20'h10000 + 20'(i), 20'h20000 + 20'(i), 1'b0);
    look(8'd6, 32'h1000_0000, "R9");
    look(8'd6, 32'h1000_8000, "R9");
    fill(8'd6, 1'b0, 20'h10009, 20'h20009, 1'b0);
    look(8'd6, 32'h1000_1000, "R9");
    inv(2'b00, 8'd6, 20'h10004);
    fill(8'd6, 1'b0, 20'h1000A, 20'h2000A, 1'b0);
    look(8'd6, 32'h1000_A000, "R9");
    look(8'd6, 32'h1000_2000, "R9");

    // random mix checked against the model
    do_reset();
    for (int n = 0; n < 1500; n++) begin
      int op;
      logic [7:0] a;
      logic [19:0] vb;
      op = $urandom_range(0, 9);
      a = 8'($urandom_range(1, 3));
      vb = {4'($urandom_range(0, 2)), 8'($urandom_range(0, 1)), 8'($urandom_range(0, 2))};
      if (op < 4) look(a, {vb, 12'($urandom)}, "R3");
      else if (op < 8) fill(a, 1'($urandom_range(0, 1)), vb, 20'($urandom), 1'($urandom_range(0, 5) == 0));
      else if (op == 8) inv(2'($urandom_range(0, 3)), a, vb);
      else cmd(1, a, 1'($urandom_range(0, 1)), vb, 20'($urandom), 1'b0,
               1, 2'($urandom_range(0, 3)), a, vb);
    end

    summary();
  end
endmodule